// File: doc/BRIEF.md
# Column-Foot Hit Buffer with Prioritised Write and Read

This block sits at the foot of one pixel column of a segmented sensor. The pixels of the column share a wired, binary-encoded row address bus and a single hit strobe. The strobe is brought into the 25 ns readout clock domain through a two-stage synchroniser. Each rising edge of the synchronised strobe produces exactly one capture of the row address, tagged with the current time stamp.

A captured hit goes into a small buffer of entries. Write-side priority logic picks the lowest-numbered free entry. Read-side priority logic moves the lowest-numbered occupied entry into an output queue, one word per clock, whenever the queue has room. A shared data bus drains the queue through a show-ahead read port.

When every buffer entry is occupied, a full indication is raised. Any hit sampled while it is raised is discarded and counted in a saturating counter. Only one hit per column per clock can be taken.

Top module: `eoc_hit_buffer`

## Requirements
- R1: After reset, `q_empty_o` is 1, `buf_full_o` is 0 and `lost_cnt_o` is 0.
- R2: A rising edge on `hit_stb_i` leads to exactly one capture. A strobe held high for many cycles captures once and no more.
- R3: Each output word carries the time stamp present at capture in bits [16:9] and the 9-bit row address in bits [8:0].
- R4: A capture is written into the lowest-numbered free buffer entry.
- R5: When the queue has room, the lowest-numbered occupied entry moves into the queue, at one word per clock, and that entry becomes free.
- R6: `buf_full_o` is 1 exactly while all 4 buffer entries are occupied.
- R7: A hit sampled while `buf_full_o` is 1 is discarded. It increments `lost_cnt_o`, which saturates at 255.
- R8: `q_data_o` shows the oldest queued word while `q_empty_o` is 0, and `q_rd_i` removes that word. A `q_rd_i` with an empty queue has no effect.
- R9: The queue holds 8 words and never accepts a word while full. With reads stopped, exactly 12 hits are retained before hits are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 ns readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_stb_i | input | 1 | Asynchronous hit strobe from the column |
| hit_row_i | input | 9 | Binary row address on the column bus |
| tstamp_i | input | 8 | Current time stamp |
| q_rd_i | input | 1 | Read request from the shared data bus |
| q_data_o | output | 17 | Head word of the queue: {time stamp, row} |
| q_empty_o | output | 1 | Queue holds no word |
| buf_full_o | output | 1 | All buffer entries occupied |
| lost_cnt_o | output | 8 | Saturating count of discarded hits |

## Verification
The assertions assume that the row address and time stamp stay stable from the rising strobe until the synchronised capture, two to three clocks later. They also assume that the strobe stays low long enough between hits for the synchroniser to see each edge. The stimulus holds both buses constant for six clocks around each strobe pulse and keeps the strobe low for at least three clocks between pulses. It drives reads only at the inactive clock edge, so the expected order of words depends only on arrival order. That order is preserved in every pattern applied: the queue either drains freely or stays fully stalled until all the retained hits are in.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
  localparam int ROW_W  = 9;
  localparam int TS_W   = 8;
  localparam int WORD_W = ROW_W + TS_W;
  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [ROW_W-1:0] row;
  } hit_word_t;
endpackage

// File: rtl/eoc_hit_sync.sv
module eoc_hit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic sample_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= stb_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sample_o = s2_q & ~s3_q;

  // R2: an edge detector can never fire on two consecutive clocks
  assert_single_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);
endmodule

// File: rtl/eoc_hit_ram.sv
module eoc_hit_ram #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 17,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              q_full_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_word_o,
  output logic              full_o,
  output logic [DROP_W-1:0] drop_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [DEPTH-1:0]  occ_q, occ_d;
  logic [DEPTH-1:0]  wr_sel, rd_sel;
  logic [IDX_W-1:0]  rd_idx;
  logic              wr_en, rd_en, drop_en;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic [WORD_W-1:0] mem_q [DEPTH];

  // write priority: lowest free entry; read priority: lowest occupied entry
  always_comb begin
    wr_sel = '0;
    rd_sel = '0;
    rd_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (!occ_q[i]) wr_sel = DEPTH'(1) << i;
      if (occ_q[i]) begin
        rd_sel = DEPTH'(1) << i;
        rd_idx = IDX_W'(i);
      end
    end
  end

  assign full_o  = &occ_q;
  assign wr_en   = sample_i & ~full_o;
  assign drop_en = sample_i & full_o & (drop_q != DROP_MAX);
  assign rd_en   = (|occ_q) & ~q_full_i;

  always_comb begin
    occ_d  = occ_q;
    if (rd_en) occ_d = occ_d & ~rd_sel;
    if (wr_en) occ_d = occ_d | wr_sel;
    drop_d = drop_q;
    if (drop_en) drop_d = drop_q + DROP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      drop_q <= '0;
    end else begin
      occ_q  <= occ_d;
      drop_q <= drop_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && wr_sel[g]) mem_q[g] <= word_i;
    end
  end

  assign push_o      = rd_en;
  assign push_word_o = mem_q[rd_idx];
  assign drop_o      = drop_q;

  assert_wr_lowest_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($onehot(wr_sel) && ((wr_sel & occ_q) == '0)
               && (((wr_sel - DEPTH'(1)) & ~occ_q) == '0)));
  assert_rd_lowest_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> ($onehot(rd_sel) && ((rd_sel & occ_q) != '0)
                && (((rd_sel - DEPTH'(1)) & occ_q) == '0)));
  assert_rd_frees_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> ((occ_q & $past(rd_sel)) == '0));
  assert_drop_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && full_o && drop_q != DROP_MAX) |=> drop_q == $past(drop_q) + DROP_W'(1));
  assert_full_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !push_o) |=> full_o);
endmodule

// File: rtl/eoc_out_fifo.sv
module eoc_out_fifo #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_word_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic [PW:0]       cnt_q, cnt_d;
  logic              do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_pop  = pop_i & ~empty_o;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_i) wptr_d = wptr_q + PW'(1);
    if (do_pop) rptr_d = rptr_q + PW'(1);
    if (push_i && !do_pop) cnt_d = cnt_q + (PW+1)'(1);
    if (!push_i && do_pop) cnt_d = cnt_q - (PW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wptr_q] <= push_word_i;
  end

  assign head_o = mem_q[rptr_q];

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> cnt_q < FULL_CNT);
  assert_empty_pop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (empty_o && $stable(rptr_q)));
endmodule

// File: rtl/eoc_hit_buffer.sv
module eoc_hit_buffer #(
  parameter int BUF_DEPTH = 4,
  parameter int Q_DEPTH   = 8,
  parameter int LOST_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hit_stb_i,
  input  logic [eoc_pkg::ROW_W-1:0]  hit_row_i,
  input  logic [eoc_pkg::TS_W-1:0]   tstamp_i,
  input  logic                       q_rd_i,
  output logic [eoc_pkg::WORD_W-1:0] q_data_o,
  output logic                       q_empty_o,
  output logic                       buf_full_o,
  output logic [LOST_W-1:0]          lost_cnt_o
);
  import eoc_pkg::*;

  logic              sample;
  hit_word_t         cap_word;
  logic              push, q_full;
  logic [WORD_W-1:0] push_word;

  assign cap_word.ts  = tstamp_i;
  assign cap_word.row = hit_row_i;

  eoc_hit_sync u_sync (
    .clk(clk), .rst_n(rst_n), .stb_i(hit_stb_i), .sample_o(sample)
  );

  eoc_hit_ram #(.DEPTH(BUF_DEPTH), .WORD_W(WORD_W), .DROP_W(LOST_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .word_i(cap_word),
    .q_full_i(q_full), .push_o(push), .push_word_o(push_word),
    .full_o(buf_full_o), .drop_o(lost_cnt_o)
  );

  eoc_out_fifo #(.DEPTH(Q_DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_word_i(push_word),
    .pop_i(q_rd_i), .head_o(q_data_o), .empty_o(q_empty_o), .full_o(q_full)
  );

  // R1: the whole block comes out of reset idle
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (q_empty_o && !buf_full_o && lost_cnt_o == '0));
endmodule

// File: tb/eoc_hit_buffer_bench.sv
module eoc_hit_buffer_bench;
  localparam time CLK_PERIOD = 25ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hit_stb;
  logic [8:0]  hit_row;
  logic [7:0]  tstamp;
  logic        q_rd;
  logic [16:0] q_data;
  logic        q_empty, buf_full;
  logic [7:0]  lost_cnt;

  int checks = 0;
  int fails  = 0;
  int popped = 0;
  bit done   = 0;
  logic [16:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eoc_hit_buffer u_eoc_hit_buffer (
    .clk(clk), .rst_n(rst_n), .hit_stb_i(hit_stb), .hit_row_i(hit_row),
    .tstamp_i(tstamp), .q_rd_i(q_rd), .q_data_o(q_data), .q_empty_o(q_empty),
    .buf_full_o(buf_full), .lost_cnt_o(lost_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one strobe pulse, buses held stable around it
  task automatic send_hit(input logic [8:0] row, input logic [7:0] ts,
                          input bit kept, input int hold = 3);
    @(negedge clk);
    hit_row = row;
    tstamp  = ts;
    hit_stb = 1'b1;
    if (kept) exp_q.push_back({ts, row});
    repeat (hold) @(negedge clk);
    hit_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares each word removed by a read (R3, R8)
  always @(negedge clk) begin
    if (rst_n && q_rd && !q_empty) begin
      popped++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 actual=%0h expected=nothing queued", q_data);
      end else begin
        check("R3 word", 32'(q_data), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hit_stb = 1'b0; hit_row = '0; tstamp = '0; q_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty", 32'(q_empty), 32'd1);
    check("R1 full", 32'(buf_full), 32'd0);
    check("R1 lost", 32'(lost_cnt), 32'd0);

    // R8: reads while empty change nothing
    q_rd = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 empty read", 32'(q_empty), 32'd1);
    check("R8 no pop", 32'(popped), 32'd0);

    // streaming hits, read enabled (R3, R5)
    for (int i = 0; i < 6; i++) send_hit(9'(i * 77 + 3), 8'(8'h10 + i * 13), 1'b1);
    send_hit(9'h1FF, 8'hFF, 1'b1);
    send_hit(9'h000, 8'h00, 1'b1);
    repeat (4) @(negedge clk);
    check("R5 drained", 32'(exp_q.size()), 32'd0);
    check("R5 pops", 32'(popped), 32'd8);

    // R2: long strobe captures once
    send_hit(9'h0AB, 8'h5C, 1'b1, 12);
    repeat (4) @(negedge clk);
    check("R2 single capture", 32'(popped), 32'd9);
    check("R2 queue empty", 32'(q_empty), 32'd1);

    // stall: 8 words in queue, 4 in buffer (R9, R6)
    q_rd = 1'b0;
    for (int i = 0; i < 11; i++) send_hit(9'(i * 31 + 100), 8'(i * 7 + 1), 1'b1);
    check("R6 not full at 11", 32'(buf_full), 32'd0);
    send_hit(9'h155, 8'hA5, 1'b1);
    check("R6 full at 12", 32'(buf_full), 32'd1);
    check("R9 nothing lost", 32'(lost_cnt), 32'd0);

    // R7: hits while full are lost and counted
    for (int i = 0; i < 3; i++) send_hit(9'h1E0, 8'hEE, 1'b0);
    check("R7 lost count", 32'(lost_cnt), 32'd3);
    for (int i = 0; i < 255; i++) send_hit(9'h1E1, 8'hEF, 1'b0);
    check("R7 saturated", 32'(lost_cnt), 32'd255);
    check("R6 still full", 32'(buf_full), 32'd1);

    // drain: retained hits come out in arrival order
    q_rd = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 retained", 32'(popped), 32'd21);
    check("R9 all matched", 32'(exp_q.size()), 32'd0);
    check("R6 full clears", 32'(buf_full), 32'd0);
    check("R8 empty after drain", 32'(q_empty), 32'd1);

    // R4: buffer reusable after drain
    send_hit(9'h0F0, 8'h42, 1'b1);
    repeat (4) @(negedge clk);
    check("R4 reuse", 32'(popped), 32'd22);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule